// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits beside the transmit and receive FIFOs of an SPI controller and keeps track of how full each one is. It counts accepted pushes and pops on both sides, derives the controller status word, latches error events (writes into a full transmit FIFO, received words arriving at a full receive FIFO, reads of an empty receive FIFO, and the chip select going inactive) as sticky interrupt sources, and combines everything with a mask into a single interrupt line. The FIFO memories and the register bus sit outside this block. Single-cycle write strobes stand in for the threshold, mask and clear registers.

The receive-threshold interrupt fires when the receive FIFO holds more words than the programmed threshold. The threshold can only be written while the controller is disabled. Dropping the controller enable flushes both fill counts to zero. The FIFO depth is a parameter, either 32 or 64, and a version output encodes it.

Top module: `spi_fstat_irq`

## Requirements
- R1: While `ctrl_en` is high, an accepted push raises the matching level by one and an accepted pop lowers it by one. A push is accepted only when the level is below DEPTH, and a pop only when the level is non-zero. A cycle with both an accepted push and an accepted pop leaves the level unchanged. The new level appears on `tx_level`/`rx_level` one clock after the strobe.
- R2: `status` bit positions are: 0 busy (`ctrl_en` and either `shift_busy` or a non-empty transmit FIFO), 1 transmit level equals DEPTH, 2 transmit level zero, 3 receive level zero, 4 receive level equals DEPTH, 5 target transmit busy (`ctrl_en` and `tgt_busy`).
- R3: A transmit push at full sets raw bit 1 (transmit overflow). A receive push at full sets raw bit 3 (receive overflow). A receive pop at empty sets raw bit 2 (receive underflow). In each case the word is dropped and the level does not change.
- R4: Raw bit 4 is high exactly when the receive level is strictly greater than the threshold, so a threshold N fires at N+1 words. Raw bit 0 follows the transmit-empty state. Raw bit 5 always reads 0.
- R5: `thr_wr` loads `thr_data` into the threshold only while `ctrl_en` is low. While enabled, the write is ignored.
- R6: While `ctrl_en` is low, both levels are zero one clock later, and pushes and pops are ignored without raising any event.
- R7: Raw bits 1, 2, 3 and 6 stay set until cleared. A `clr_wr` strobe clears a bit if `clr_data` has its own bit set or bit 0 (clear-all) set. Own bits: 1 clears receive underflow (raw 2), 2 clears receive overflow (raw 3), 3 clears transmit overflow (raw 1). Raw bit 6 is cleared only by clear-all.
- R8: If an event arrives in the same cycle as the clear for its bit, the bit remains set.
- R9: `masked_irq` equals `raw_irq` AND the mask register, and `irq` is the OR of `masked_irq`. `mask_wr` loads `mask_data`. The mask resets to zero, which silences every source.
- R10: A high-to-low transition of `sel_active` while `ctrl_en` is high sets raw bit 6.
- R11: After reset, both levels are 0, the mask and sticky bits are 0, and the threshold is DEPTH/2-1. `ver_code` equals log2(DEPTH): 5 for 32 entries, 6 for 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; low flushes both FIFOs |
| shift_busy | input | 1 | Shift engine is moving a frame |
| tgt_busy | input | 1 | Target-mode transmit still in progress |
| sel_active | input | 1 | Chip select currently asserted |
| tx_push | input | 1 | Word written into the transmit FIFO |
| tx_pop | input | 1 | Word taken from the transmit FIFO by the shifter |
| rx_push | input | 1 | Received word delivered to the receive FIFO |
| rx_pop | input | 1 | Word read from the receive FIFO |
| thr_wr | input | 1 | Threshold write strobe |
| thr_data | input | LVL_W | Threshold value |
| mask_wr | input | 1 | Mask write strobe |
| mask_data | input | 7 | Mask value, same layout as raw_irq |
| clr_wr | input | 1 | Clear write strobe |
| clr_data | input | 4 | Clear bit map |
| tx_level | output | LVL_W | Transmit FIFO fill level |
| rx_level | output | LVL_W | Receive FIFO fill level |
| status | output | 6 | Status word |
| raw_irq | output | 7 | Unmasked interrupt sources |
| masked_irq | output | 7 | Sources after masking |
| irq | output | 1 | Combined interrupt line |
| ver_code | output | 4 | log2 of FIFO depth |

## Verification
The hardest states to reach are a full FIFO and a threshold crossing, because each needs dozens of accepted pushes. The bench gets there with counted push bursts and checks the exact word where the receive-threshold source turns on. It also tests the race between an event and its own clear strobe in the same cycle, which only arises when a pop at empty and a clear write are driven together on one edge. A threshold write made while enabled is checked through its effect on the threshold comparison at a known receive level.

// File: rtl/spi_fstat_pkg.sv
package spi_fstat_pkg;
   // status word bit positions
   localparam int ST_BUSY    = 0;
   localparam int ST_TXFULL  = 1;
   localparam int ST_TXEMPTY = 2;
   localparam int ST_RXEMPTY = 3;
   localparam int ST_RXFULL  = 4;
   localparam int ST_TGTBUSY = 5;
   localparam int ST_W       = 6;
   // interrupt bit positions
   localparam int IR_TXEMPTY = 0;
   localparam int IR_TXOVF   = 1;
   localparam int IR_RXUDF   = 2;
   localparam int IR_RXOVF   = 3;
   localparam int IR_RXTHR   = 4;
   localparam int IR_SELOFF  = 6;
   localparam int IR_W       = 7;
   // clear map bit positions
   localparam int CL_ALL     = 0;
   localparam int CL_RXUDF   = 1;
   localparam int CL_RXOVF   = 2;
   localparam int CL_TXOVF   = 3;
   localparam int CL_W       = 4;
   // sticky bank slots
   localparam int SK_TXOVF   = 0;
   localparam int SK_RXUDF   = 1;
   localparam int SK_RXOVF   = 2;
   localparam int SK_SELOFF  = 3;
   localparam int SK_N       = 4;
endpackage

// File: rtl/sfi_level_track.sv
module sfi_level_track #(
   parameter int DEPTH = 32,
   parameter int LVL_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             push,
   input  logic             pop,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty,
   output logic             ovf_evt,
   output logic             udf_evt
);
   localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

   logic acc_push, acc_pop;

   assign full     = (level == LVL_MAX);
   assign empty    = (level == '0);
   assign acc_push = en & push & ~full;
   assign acc_pop  = en & pop & ~empty;
   assign ovf_evt  = en & push & full;
   assign udf_evt  = en & pop & empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= '0;
      end else if (!en) begin
         level <= '0;
      end else if (acc_push && !acc_pop) begin
         level <= level + LVL_W'(1);
      end else if (acc_pop && !acc_push) begin
         level <= level - LVL_W'(1);
      end
   end

   assert_level_bound_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_MAX);
   assert_flush_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> level == '0);
   assert_drop_full_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && push && !pop && full) |=> level == LVL_MAX);
endmodule

// File: rtl/sfi_sticky_bank.sv
module sfi_sticky_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] clr,
   output logic [N-1:0] stk
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stk[i] <= 1'b0;
         else if (evt[i]) stk[i] <= 1'b1;
         else if (clr[i]) stk[i] <= 1'b0;
      end

      assert_evt_wins_R8 : assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> stk[i]);
      assert_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
         (stk[i] && !clr[i]) |=> stk[i]);
   end
endmodule

// File: rtl/sfi_irq_core.sv
module sfi_irq_core
   import spi_fstat_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int LVL_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             thr_wr,
   input  logic [LVL_W-1:0] thr_data,
   input  logic             mask_wr,
   input  logic [IR_W-1:0]  mask_data,
   input  logic [LVL_W-1:0] rx_level,
   input  logic             tx_empty,
   input  logic [SK_N-1:0]  stk,
   output logic [LVL_W-1:0] thr_q,
   output logic [IR_W-1:0]  raw,
   output logic [IR_W-1:0]  masked,
   output logic             irq
);
   localparam logic [LVL_W-1:0] THR_RST = LVL_W'(DEPTH / 2 - 1);

   logic [IR_W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q  <= THR_RST;
         mask_q <= '0;
      end else begin
         if (thr_wr && !en) thr_q  <= thr_data;
         if (mask_wr)       mask_q <= mask_data;
      end
   end

   always_comb begin
      raw             = '0;
      raw[IR_TXEMPTY] = tx_empty;
      raw[IR_TXOVF]   = stk[SK_TXOVF];
      raw[IR_RXUDF]   = stk[SK_RXUDF];
      raw[IR_RXOVF]   = stk[SK_RXOVF];
      raw[IR_RXTHR]   = (rx_level > thr_q);
      raw[IR_SELOFF]  = stk[SK_SELOFF];
   end

   assign masked = raw & mask_q;
   assign irq    = |masked;

   assert_thr_lock_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      en |=> $stable(thr_q));
   assert_mask_silence_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);
endmodule

// File: rtl/spi_fstat_irq.sv
module spi_fstat_irq
   import spi_fstat_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int LVL_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_en,
   input  logic             shift_busy,
   input  logic             tgt_busy,
   input  logic             sel_active,
   input  logic             tx_push,
   input  logic             tx_pop,
   input  logic             rx_push,
   input  logic             rx_pop,
   input  logic             thr_wr,
   input  logic [LVL_W-1:0] thr_data,
   input  logic             mask_wr,
   input  logic [6:0]       mask_data,
   input  logic             clr_wr,
   input  logic [3:0]       clr_data,
   output logic [LVL_W-1:0] tx_level,
   output logic [LVL_W-1:0] rx_level,
   output logic [5:0]       status,
   output logic [6:0]       raw_irq,
   output logic [6:0]       masked_irq,
   output logic             irq,
   output logic [3:0]       ver_code
);
   if (!(DEPTH == 32 || DEPTH == 64)) begin : g_bad_depth
      $error("spi_fstat_irq: DEPTH must be 32 or 64");
   end

   if (DEPTH == 64) begin : g_ver64
      assign ver_code = 4'd6;
   end else begin : g_ver32
      assign ver_code = 4'd5;
   end

   logic tx_full, tx_empty, rx_full, rx_empty;
   logic tx_ovf, tx_udf_unused, rx_ovf, rx_udf;
   logic sel_q;
   logic [SK_N-1:0] evt, clr, stk;
   logic [LVL_W-1:0] thr_q;

   sfi_level_track #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_tx_lvl (
      .clk(clk), .rst_n(rst_n), .en(ctrl_en), .push(tx_push), .pop(tx_pop),
      .level(tx_level), .full(tx_full), .empty(tx_empty),
      .ovf_evt(tx_ovf), .udf_evt(tx_udf_unused));

   sfi_level_track #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rx_lvl (
      .clk(clk), .rst_n(rst_n), .en(ctrl_en), .push(rx_push), .pop(rx_pop),
      .level(rx_level), .full(rx_full), .empty(rx_empty),
      .ovf_evt(rx_ovf), .udf_evt(rx_udf));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= sel_active;
   end

   always_comb begin
      evt            = '0;
      evt[SK_TXOVF]  = tx_ovf;
      evt[SK_RXUDF]  = rx_udf;
      evt[SK_RXOVF]  = rx_ovf;
      evt[SK_SELOFF] = ctrl_en & sel_q & ~sel_active;
      clr            = '0;
      clr[SK_TXOVF]  = clr_wr & (clr_data[CL_ALL] | clr_data[CL_TXOVF]);
      clr[SK_RXUDF]  = clr_wr & (clr_data[CL_ALL] | clr_data[CL_RXUDF]);
      clr[SK_RXOVF]  = clr_wr & (clr_data[CL_ALL] | clr_data[CL_RXOVF]);
      clr[SK_SELOFF] = clr_wr & clr_data[CL_ALL];
   end

   sfi_sticky_bank #(.N(SK_N)) u_sticky (
      .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr), .stk(stk));

   sfi_irq_core #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .en(ctrl_en),
      .thr_wr(thr_wr), .thr_data(thr_data),
      .mask_wr(mask_wr), .mask_data(mask_data),
      .rx_level(rx_level), .tx_empty(tx_empty), .stk(stk),
      .thr_q(thr_q), .raw(raw_irq), .masked(masked_irq), .irq(irq));

   always_comb begin
      status             = '0;
      status[ST_BUSY]    = ctrl_en & (shift_busy | ~tx_empty);
      status[ST_TXFULL]  = tx_full;
      status[ST_TXEMPTY] = tx_empty;
      status[ST_RXEMPTY] = rx_empty;
      status[ST_RXFULL]  = rx_full;
      status[ST_TGTBUSY] = ctrl_en & tgt_busy;
   end

   assert_clear_all_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_data[CL_ALL] && !ctrl_en) |=> (raw_irq[IR_TXOVF] == 1'b0
                                                   && raw_irq[IR_SELOFF] == 1'b0));
   assert_seloff_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && $fell(sel_active)) |=> raw_irq[IR_SELOFF]);
endmodule

// File: tb/spi_fstat_irq_tb.sv
module spi_fstat_irq_tb;
   localparam int DEPTH = 32;
   localparam int LW    = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctrl_en = 0, shift_busy = 0, tgt_busy = 0, sel_active = 0;
   logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
   logic thr_wr = 0, mask_wr = 0, clr_wr = 0;
   logic [LW-1:0] thr_data = '0;
   logic [6:0] mask_data = '0;
   logic [3:0] clr_data = '0;
   logic [LW-1:0] tx_level, rx_level;
   logic [5:0] status;
   logic [6:0] raw_irq, masked_irq;
   logic irq;
   logic [3:0] ver_code;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   spi_fstat_irq #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .shift_busy(shift_busy),
      .tgt_busy(tgt_busy), .sel_active(sel_active),
      .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
      .thr_wr(thr_wr), .thr_data(thr_data), .mask_wr(mask_wr), .mask_data(mask_data),
      .clr_wr(clr_wr), .clr_data(clr_data), .tx_level(tx_level), .rx_level(rx_level),
      .status(status), .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq),
      .ver_code(ver_code));

   // ops {tx_push, tx_pop, rx_push, rx_pop}, expected tx level, expected rx level
   localparam int NV = 8;
   localparam logic [15:0] VEC [NV] = '{
      {4'b1000, 6'd1, 6'd0},
      {4'b1000, 6'd2, 6'd0},
      {4'b1100, 6'd2, 6'd0},
      {4'b0010, 6'd2, 6'd1},
      {4'b0110, 6'd1, 6'd2},
      {4'b0001, 6'd1, 6'd1},
      {4'b0101, 6'd0, 6'd0},
      {4'b0000, 6'd0, 6'd0}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
      thr_wr = 0; mask_wr = 0; clr_wr = 0;
   endtask

   task automatic push_tx(input int n);
      for (int i = 0; i < n; i++) begin
         tx_push = 1;
         step();
      end
   endtask

   task automatic push_rx(input int n);
      for (int i = 0; i < n; i++) begin
         rx_push = 1;
         step();
      end
   endtask

   task automatic clear(input logic [3:0] m);
      clr_wr = 1; clr_data = m;
      step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      check("R11 tx_level", tx_level, 0);
      check("R11 rx_level", rx_level, 0);
      check("R11 ver_code", ver_code, 5);
      check("R2 reset status", status, 6'h0C);
      check("R4 reset raw", raw_irq, 7'h01);
      check("R9 reset irq", irq, 0);

      ctrl_en = 1;
      step();
      // R1 vector table
      for (int v = 0; v < NV; v++) begin
         {tx_push, tx_pop, rx_push, rx_pop} = VEC[v][15:12];
         step();
         check("R1 tx_level", tx_level, int'(VEC[v][11:6]));
         check("R1 rx_level", rx_level, int'(VEC[v][5:0]));
      end
      check("R3 no spurious events", raw_irq & 7'h4E, 0);

      // R3 underflow
      rx_pop = 1; step();
      check("R3 rx underflow", raw_irq[2], 1);
      check("R3 rx level stays", rx_level, 0);
      // R7 persistence and per-source clear
      step(); step();
      check("R7 sticky holds", raw_irq[2], 1);
      clear(4'b0100);
      check("R7 other clear ignored", raw_irq[2], 1);
      clear(4'b0010);
      check("R7 own clear", raw_irq[2], 0);
      // R8 event wins
      rx_pop = 1; clr_wr = 1; clr_data = 4'b0010;
      step();
      check("R8 event beats clear", raw_irq[2], 1);
      clear(4'b0010);
      check("R8 later clear", raw_irq[2], 0);

      // R2/R3 transmit full
      push_tx(DEPTH);
      check("R1 tx full level", tx_level, DEPTH);
      check("R2 status tx full", status, 6'h0B);
      tx_push = 1; step();
      check("R3 tx overflow", raw_irq[1], 1);
      check("R3 tx level held", tx_level, DEPTH);

      // R5 locked threshold, R4 threshold crossing
      push_rx(3);
      thr_wr = 1; thr_data = 6'd1; step();
      check("R5 write ignored while enabled", raw_irq[4], 0);
      push_rx(12);
      check("R4 at threshold", raw_irq[4], 0);
      push_rx(1);
      check("R4 above threshold", raw_irq[4], 1);
      push_rx(16);
      check("R2 rx full", status[4], 1);
      rx_push = 1; step();
      check("R3 rx overflow", raw_irq[3], 1);
      check("R3 rx level held", rx_level, DEPTH);
      check("R4 bit5 zero", raw_irq[5], 0);

      // R9 masking
      mask_wr = 1; mask_data = 7'h08; step();
      check("R9 masked", masked_irq, 7'h08);
      check("R9 irq", irq, 1);
      mask_wr = 1; mask_data = 7'h00; step();
      check("R9 mask zero", irq, 0);

      // R6 flush
      ctrl_en = 0; step();
      check("R6 tx flush", tx_level, 0);
      check("R6 rx flush", rx_level, 0);
      check("R7 sticky after disable", raw_irq & 7'h0A, 7'h0A);
      clear(4'b0001);
      check("R7 clear all", raw_irq & 7'h4E, 0);
      rx_pop = 1; tx_push = 1; step();
      check("R6 no underflow when disabled", raw_irq[2], 0);
      check("R6 push ignored", tx_level, 0);

      // R5 threshold write while disabled
      thr_wr = 1; thr_data = 6'd1; step();
      ctrl_en = 1; step();
      push_rx(1);
      check("R5 new threshold not reached", raw_irq[4], 0);
      push_rx(1);
      check("R5 new threshold fires", raw_irq[4], 1);

      // R10 select inactive
      sel_active = 1; step();
      sel_active = 0; step();
      check("R10 select off", raw_irq[6], 1);
      clear(4'b1110);
      check("R10 only clear-all", raw_irq[6], 1);
      clear(4'b0001);
      check("R10 cleared", raw_irq[6], 0);

      // R2 target busy and shift busy
      tgt_busy = 1; shift_busy = 1; step();
      check("R2 target busy", status[5], 1);
      check("R2 busy", status[0], 1);
      ctrl_en = 0; step();
      check("R2 target busy gated", status[5], 0);
      check("R2 busy gated", status[0], 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule